// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of every line of one processor's cache on a shared snooping bus. Each line is in one of four states: Modified, Exclusive, Shared or Invalid. The block takes local requests from the processor side. A request is a read or a write, together with a tag-match flag and a line index. It also takes transactions that other agents put on the bus: a read, a read-for-ownership, or an invalidate, each with a line index and a tag-match flag computed outside the block. From these inputs it produces the next state of each line.

When another agent reads a line that this cache holds, the block drives a shared response on the bus in the same cycle. If the line is Modified, the block also raises a flush request in the same cycle, so the owner supplies the dirty data. Local misses and writes to Shared lines need a bus transaction. For these the block issues a command carrying the line index, then holds it until the bus grants it. Only one command can be outstanding at a time. While a command is outstanding, the block reports busy.

Data arrays, tag comparison, victim selection and the memory controller are outside this block. The full state vector is brought out, so that the surrounding cache logic can use it.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line reads Invalid. The encoding is 2 bits per line in `line_state_o[2*i+1:2*i]`, with Invalid=0, Shared=1, Exclusive=2, Modified=3. After reset no bus command is requested and `lcl_busy_o` is low.
- R2: A local read that misses (the tag flag is low or the line is Invalid) requests a bus read, with `bus_op_o`=1 and `bus_idx_o` set to the line. On grant the line becomes Shared if `bus_shared_i` is high, and Exclusive otherwise.
- R3: A local write that misses requests a read-for-ownership (`bus_op_o`=2). On grant the line becomes Modified.
- R4: A local write hit on an Exclusive line turns it Modified with no bus command. Read hits on Modified, Exclusive or Shared lines leave the state unchanged, and so do write hits on Modified lines. None of these issues a command.
- R5: A local write hit on a Shared line requests an upgrade (`bus_op_o`=3). On grant the line becomes Modified.
- R6: A snooped read (`snp_op_i`=1, tag flag high) on a Modified line raises `snp_flush_o` and `snp_shared_o` in the same cycle. The line then becomes Shared.
- R7: A snooped read-for-ownership (`snp_op_i`=2) on a Modified line raises `snp_flush_o`. The line then becomes Invalid.
- R8: A snooped read on an Exclusive or Shared line raises `snp_shared_o` without a flush, and the line becomes Shared. A snooped read-for-ownership or invalidate (`snp_op_i`=3) on an Exclusive or Shared line makes it Invalid, without a flush.
- R9: A snoop does not change any state and raises no response in either of two cases: its tag flag is low, or the addressed line is Invalid.
- R10: While a command is outstanding, `lcl_busy_o` is high and local requests are ignored. `bus_req_o`, `bus_op_o` and `bus_idx_o` stay stable until `bus_gnt_i` is seen.
- R11: A snoop and a local request may address the same line in one cycle. In that case the snoop takes effect first, and the local request is decided against the resulting state. For example, a write to an Exclusive line that is hit by a snooped read-for-ownership becomes a read-for-ownership miss.
- R12: An outstanding upgrade whose line is invalidated by a snoop is turned into a read-for-ownership (`bus_op_o`=2). This takes effect in the same cycle as the snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcl_valid_i | input | 1 | Local request present |
| lcl_write_i | input | 1 | Local request is a write |
| lcl_hit_i | input | 1 | Local tag matched |
| lcl_idx_i | input | IDX_W | Local line index |
| lcl_busy_o | output | 1 | A bus command is outstanding |
| snp_valid_i | input | 1 | Snooped transaction present |
| snp_op_i | input | 2 | Snoop kind: 1 read, 2 read-for-ownership, 3 invalidate |
| snp_hit_i | input | 1 | Snooped tag matched this cache |
| snp_idx_i | input | IDX_W | Snooped line index |
| snp_shared_o | output | 1 | Shared response to a snooped read |
| snp_flush_o | output | 1 | Supply dirty line data on the bus |
| bus_req_o | output | 1 | Bus command request |
| bus_op_o | output | 2 | Command: 1 read, 2 read-for-ownership, 3 upgrade |
| bus_idx_o | output | IDX_W | Line index of the command |
| bus_gnt_i | input | 1 | Grant of the outstanding command |
| bus_shared_i | input | 1 | Shared response seen at grant of a bus read |
| line_state_o | output | 2*NUM_LINES | State of every line |

## Verification
The bench builds the block with NUM_LINES=4. With only four indices, random local requests, snoops and grants hit the same line often. This makes same-cycle collisions, snoops against an outstanding upgrade, and grants that coincide with snoops frequent rather than rare. The directed sequences reach each state transition in turn. A random phase then compares every output with the behavioural model on every cycle.

// File: rtl/mesi_lc_pkg.sv
package mesi_lc_pkg;
  typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_E = 2'd2, LS_M = 2'd3} line_st_e;
  typedef enum logic [1:0] {SN_NONE = 2'd0, SN_READ = 2'd1, SN_RFO = 2'd2, SN_INV = 2'd3} snp_op_e;
  typedef enum logic [1:0] {BC_IDLE = 2'd0, BC_READ = 2'd1, BC_RFO = 2'd2, BC_UPGR = 2'd3} bus_op_e;
endpackage

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_lc_pkg::*;
(
  input  logic       snp_valid,
  input  logic       snp_hit,
  input  logic [1:0] snp_op,
  input  logic [1:0] cur_st,
  output logic [1:0] nxt_st,
  output logic       shared,
  output logic       flush
);
  logic held;

  always_comb begin
    held   = snp_valid && snp_hit && (line_st_e'(cur_st) != LS_I);
    nxt_st = cur_st;
    shared = 1'b0;
    flush  = 1'b0;
    if (held) begin
      case (snp_op_e'(snp_op))
        SN_READ: begin
          nxt_st = LS_S;
          shared = 1'b1;
          flush  = (line_st_e'(cur_st) == LS_M);
        end
        SN_RFO, SN_INV: begin
          nxt_st = LS_I;
          flush  = (line_st_e'(cur_st) == LS_M);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mesi_local_eval.sv
module mesi_local_eval
  import mesi_lc_pkg::*;
(
  input  logic       req_go,
  input  logic       req_write,
  input  logic       req_hit,
  input  logic [1:0] cur_st,
  output logic       upd,
  output logic [1:0] nxt_st,
  output logic       issue,
  output logic [1:0] issue_op
);
  logic present;

  always_comb begin
    present  = req_hit && (line_st_e'(cur_st) != LS_I);
    upd      = 1'b0;
    nxt_st   = cur_st;
    issue    = 1'b0;
    issue_op = BC_IDLE;
    if (req_go) begin
      if (!present) begin
        issue    = 1'b1;
        issue_op = req_write ? BC_RFO : BC_READ;
      end else if (req_write) begin
        case (line_st_e'(cur_st))
          LS_S: begin
            issue    = 1'b1;
            issue_op = BC_UPGR;
          end
          LS_E: begin
            upd    = 1'b1;
            nxt_st = LS_M;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mesi_bus_issuer.sv
module mesi_bus_issuer
  import mesi_lc_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [1:0]       issue_op,
  input  logic [IDX_W-1:0] issue_idx,
  input  logic             gnt,
  input  logic [1:0]       pend_line_st,
  output logic             pend_valid,
  output logic [1:0]       pend_op,
  output logic [IDX_W-1:0] pend_idx,
  output logic             done
);
  logic             vld_q, vld_d;
  logic [1:0]       op_q, op_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             lost;
  logic             en;

  always_comb begin
    lost    = vld_q && (bus_op_e'(op_q) == BC_UPGR) && (line_st_e'(pend_line_st) == LS_I);
    pend_op = lost ? BC_RFO : op_q;
    done    = vld_q && gnt;
    vld_d   = vld_q;
    op_d    = pend_op;
    idx_d   = idx_q;
    if (done) begin
      vld_d = 1'b0;
    end else if (!vld_q && issue) begin
      vld_d = 1'b1;
      op_d  = issue_op;
      idx_d = issue_idx;
    end
    en = (vld_d != vld_q) || (op_d != op_q) || (idx_d != idx_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      op_q  <= BC_IDLE;
      idx_q <= '0;
    end else if (en) begin
      vld_q <= vld_d;
      op_q  <= op_d;
      idx_q <= idx_d;
    end
  end

  assign pend_valid = vld_q;
  assign pend_idx   = idx_q;
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_lc_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lcl_valid_i,
  input  logic                   lcl_write_i,
  input  logic                   lcl_hit_i,
  input  logic [IDX_W-1:0]       lcl_idx_i,
  output logic                   lcl_busy_o,
  input  logic                   snp_valid_i,
  input  logic [1:0]             snp_op_i,
  input  logic                   snp_hit_i,
  input  logic [IDX_W-1:0]       snp_idx_i,
  output logic                   snp_shared_o,
  output logic                   snp_flush_o,
  output logic                   bus_req_o,
  output logic [1:0]             bus_op_o,
  output logic [IDX_W-1:0]       bus_idx_o,
  input  logic                   bus_gnt_i,
  input  logic                   bus_shared_i,
  output logic [2*NUM_LINES-1:0] line_state_o
);
  logic [1:0] st_q   [NUM_LINES];
  logic [1:0] st_snp [NUM_LINES];
  logic [1:0] st_d   [NUM_LINES];

  logic [1:0]       snp_nxt;
  logic             loc_upd, loc_issue;
  logic [1:0]       loc_nxt, loc_op;
  logic             pend_valid, fill_done;
  logic [1:0]       pend_op, fill_st;
  logic [IDX_W-1:0] pend_idx;

  mesi_snoop_resp u_snoop (
    .snp_valid (snp_valid_i),
    .snp_hit   (snp_hit_i),
    .snp_op    (snp_op_i),
    .cur_st    (st_q[snp_idx_i]),
    .nxt_st    (snp_nxt),
    .shared    (snp_shared_o),
    .flush     (snp_flush_o)
  );

  mesi_local_eval u_local (
    .req_go    (lcl_valid_i && !pend_valid),
    .req_write (lcl_write_i),
    .req_hit   (lcl_hit_i),
    .cur_st    (st_snp[lcl_idx_i]),
    .upd       (loc_upd),
    .nxt_st    (loc_nxt),
    .issue     (loc_issue),
    .issue_op  (loc_op)
  );

  mesi_bus_issuer #(.IDX_W(IDX_W)) u_issuer (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue        (loc_issue),
    .issue_op     (loc_op),
    .issue_idx    (lcl_idx_i),
    .gnt          (bus_gnt_i),
    .pend_line_st (st_snp[pend_idx]),
    .pend_valid   (pend_valid),
    .pend_op      (pend_op),
    .pend_idx     (pend_idx),
    .done         (fill_done)
  );

  assign fill_st    = (bus_op_e'(pend_op) == BC_READ) ? (bus_shared_i ? LS_S : LS_E) : LS_M;
  assign lcl_busy_o = pend_valid;
  assign bus_req_o  = pend_valid;
  assign bus_op_o   = pend_valid ? pend_op : BC_IDLE;
  assign bus_idx_o  = pend_idx;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam logic [IDX_W-1:0] LINE = IDX_W'(i);
    logic en;

    always_comb begin
      st_snp[i] = (snp_idx_i == LINE) ? snp_nxt : st_q[i];
      st_d[i]   = st_snp[i];
      if (loc_upd && (lcl_idx_i == LINE)) st_d[i] = loc_nxt;
      if (fill_done && (pend_idx == LINE)) st_d[i] = fill_st;
      en = (st_d[i] != st_q[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i] <= LS_I;
      end else if (en) begin
        st_q[i] <= st_d[i];
      end
    end

    assign line_state_o[2*i +: 2] = st_q[i];
  end
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   snp_valid_i,
  input logic [1:0]             snp_op_i,
  input logic                   snp_hit_i,
  input logic [IDX_W-1:0]       snp_idx_i,
  input logic                   snp_shared_o,
  input logic                   snp_flush_o,
  input logic                   bus_req_o,
  input logic [1:0]             bus_op_o,
  input logic [IDX_W-1:0]       bus_idx_o,
  input logic                   bus_gnt_i,
  input logic [2*NUM_LINES-1:0] line_state_o
);
  logic [IDX_W-1:0] snp_idx_q;
  logic             rst_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snp_idx_q  <= '0;
      rst_seen_q <= 1'b1;
    end else begin
      snp_idx_q  <= snp_idx_i;
      rst_seen_q <= 1'b0;
    end
  end

  // R1: first cycle out of reset shows all lines Invalid and no request
  p_reset_invalid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_seen_q |-> (line_state_o == '0) && !bus_req_o);

  // R6: a flushed line is no longer Modified afterwards (unless a fill lands on it)
  p_flush_leaves_mod_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_flush_o && !(bus_req_o && bus_gnt_i && bus_idx_o == snp_idx_i))
      |=> line_state_o[{snp_idx_q, 1'b0} +: 2] != 2'd3);

  // R8: shared response only answers a snooped read that matched
  p_shared_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared_o |-> snp_valid_i && snp_hit_i && (snp_op_i == 2'd1));

  // R10: request held steady until granted
  p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_gnt_i) |=> bus_req_o && $stable(bus_idx_o));

  // R5: an upgrade is only shown for a line still Shared
  p_upgr_from_shared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && bus_op_o == 2'd3) |-> line_state_o[{bus_idx_o, 1'b0} +: 2] == 2'd1);
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .snp_valid_i  (snp_valid_i),
  .snp_op_i     (snp_op_i),
  .snp_hit_i    (snp_hit_i),
  .snp_idx_i    (snp_idx_i),
  .snp_shared_o (snp_shared_o),
  .snp_flush_o  (snp_flush_o),
  .bus_req_o    (bus_req_o),
  .bus_op_o     (bus_op_o),
  .bus_idx_o    (bus_idx_o),
  .bus_gnt_i    (bus_gnt_i),
  .line_state_o (line_state_o)
);

// File: tb/test_mesi_line_ctrl.sv
`timescale 1ns/1ps
module test_mesi_line_ctrl;
  localparam int NL = 4;
  localparam int IW = 2;

  logic clk, rst_n;
  logic lcl_valid, lcl_write, lcl_hit, lcl_busy;
  logic [IW-1:0] lcl_idx, snp_idx, bus_idx;
  logic snp_valid, snp_hit, snp_shared, snp_flush;
  logic [1:0] snp_op, bus_op;
  logic bus_req, bus_gnt, bus_shared;
  logic [2*NL-1:0] line_state;

  mesi_line_ctrl #(.NUM_LINES(NL)) i_mesi_line_ctrl (
    .clk(clk), .rst_n(rst_n),
    .lcl_valid_i(lcl_valid), .lcl_write_i(lcl_write), .lcl_hit_i(lcl_hit),
    .lcl_idx_i(lcl_idx), .lcl_busy_o(lcl_busy),
    .snp_valid_i(snp_valid), .snp_op_i(snp_op), .snp_hit_i(snp_hit),
    .snp_idx_i(snp_idx), .snp_shared_o(snp_shared), .snp_flush_o(snp_flush),
    .bus_req_o(bus_req), .bus_op_o(bus_op), .bus_idx_o(bus_idx),
    .bus_gnt_i(bus_gnt), .bus_shared_i(bus_shared), .line_state_o(line_state)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int vecs = 0;
  int errs = 0;
  string tag = "R1";

  // reference model: states 0=I 1=S 2=E 3=M; commands 1 read 2 rfo 3 upgrade
  int ms[NL];
  int pv, pc, pidx;

  task automatic chk(string what, int act, int exp);
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(bit lv, bit lw, bit lh, int li, bit sv, int sop, bit sh, int si,
                      bit gnt, bit bsh);
    int post[NL];
    int nms[NL];
    int epc, npv, npc, npi, st;
    bit e_sh, e_fl;
    @(negedge clk);
    lcl_valid = lv; lcl_write = lw; lcl_hit = lh; lcl_idx = IW'(li);
    snp_valid = sv; snp_op = 2'(sop); snp_hit = sh; snp_idx = IW'(si);
    bus_gnt = gnt; bus_shared = bsh;
    #1;
    foreach (ms[k]) post[k] = ms[k];
    e_sh = sv && sh && sop == 1 && ms[si] != 0;
    e_fl = sv && sh && sop != 0 && ms[si] == 3;
    if (sv && sh && sop != 0 && ms[si] != 0) post[si] = (sop == 1) ? 1 : 0;
    epc = pc;
    if (pv != 0 && pc == 3 && post[pidx] == 0) epc = 2;
    vecs++;
    chk("snp_shared", int'(snp_shared), int'(e_sh));
    chk("snp_flush", int'(snp_flush), int'(e_fl));
    chk("bus_req", int'(bus_req), pv);
    chk("busy", int'(lcl_busy), pv);
    if (pv != 0) begin
      chk("bus_op", int'(bus_op), epc);
      chk("bus_idx", int'(bus_idx), pidx);
    end
    for (int k = 0; k < NL; k++) chk($sformatf("line%0d", k), int'(line_state[2*k +: 2]), ms[k]);
    foreach (post[k]) nms[k] = post[k];
    npv = pv; npc = epc; npi = pidx;
    if (pv != 0) begin
      if (gnt) begin
        nms[pidx] = (epc == 1) ? (bsh ? 1 : 2) : 3;
        npv = 0;
      end
    end else if (lv) begin
      st = post[li];
      if (!lh || st == 0) begin
        npv = 1; npc = lw ? 2 : 1; npi = li;
      end else if (lw) begin
        if (st == 1) begin npv = 1; npc = 3; npi = li; end
        else nms[li] = 3;
      end
    end
    @(posedge clk);
    foreach (ms[k]) ms[k] = nms[k];
    pv = npv; pc = npc; pidx = npi;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic lreq(bit w, bit h, int i);
    step(1, w, h, i, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic grant(bit bsh);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, bsh);
  endtask

  task automatic snoop(int op, bit h, int i);
    step(0, 0, 0, 0, 1, op, h, i, 0, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    lcl_valid = 0; lcl_write = 0; lcl_hit = 0; lcl_idx = '0;
    snp_valid = 0; snp_op = '0; snp_hit = 0; snp_idx = '0;
    bus_gnt = 0; bus_shared = 0;
    foreach (ms[k]) ms[k] = 0;
    pv = 0; pc = 0; pidx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    tag = "R1"; idle(2);
    tag = "R2"; lreq(0, 0, 0); idle(1); grant(0);
    lreq(0, 1, 1); grant(1);
    tag = "R10"; lreq(1, 0, 2); lreq(0, 0, 3); lreq(1, 1, 0); idle(1);
    tag = "R3"; grant(0);
    tag = "R4"; lreq(1, 1, 0); lreq(0, 1, 0); lreq(1, 1, 0); lreq(0, 1, 1); lreq(0, 1, 2); idle(1);
    tag = "R5"; lreq(1, 1, 1); idle(1); grant(0); idle(1);
    tag = "R6"; snoop(1, 1, 0); idle(1);
    tag = "R7"; snoop(2, 1, 2); idle(1);
    tag = "R8"; lreq(0, 0, 3); grant(0); snoop(1, 1, 3); snoop(3, 1, 3);
    lreq(0, 0, 3); grant(0); snoop(2, 1, 3); idle(1);
    tag = "R9"; snoop(2, 0, 1); snoop(1, 1, 2); snoop(3, 1, 3); idle(1);
    tag = "R11"; lreq(0, 0, 3); grant(0);
    step(1, 1, 1, 3, 1, 2, 1, 3, 0, 0); idle(1); grant(0); idle(1);
    tag = "R12"; lreq(1, 1, 0); snoop(3, 1, 0); idle(1); grant(0); idle(1);
    lreq(0, 0, 2); grant(1); lreq(1, 1, 2); step(0, 0, 0, 0, 1, 2, 1, 2, 1, 0); idle(2);
    tag = "R11";
    for (int n = 0; n < 1500; n++) begin
      step(1'($urandom), 1'($urandom), 1'($urandom % 4 != 0), int'($urandom % NL),
           1'($urandom), int'($urandom % 4), 1'($urandom % 4 != 0), int'($urandom % NL),
           1'($urandom % 3 == 0), 1'($urandom));
    end
    summary();
  end
endmodule